// File: doc/BRIEF.md
# Single-Precision to 8-bit Float Converter

This block narrows a 32-bit IEEE single-precision value to one of two 8-bit floating-point encodings. A select input picks the target on each transfer. One target has a 3-bit fraction, a 4-bit exponent and bias 7. It has no infinity and keeps a single NaN pattern. The other target has a 2-bit fraction, a 5-bit exponent and bias 15, and it follows IEEE conventions, including infinity. The result is rounded to the nearest representable value, with ties to even. This holds for normal and subnormal results. Values too large for the target saturate or become infinity, as the target's rules require.

The block sits on a datapath that quantizes weights, activations or cached keys and values after a scale factor has been applied. A bfloat16 source is widened by appending sixteen zero bits before it reaches this block. Each input word carries a valid strobe. The result and its strobe appear from a register one clock later.

Top module: `fp8_cvt`

## Requirements
- R1: After reset, valid_o and data_o are zero. valid_o equals the valid_i of the previous clock edge, and data_o carries the result of the word accepted at that edge.
- R2: When valid_i is low at a clock edge, data_o keeps its previous value.
- R3: fmt_i = 0 selects the narrow-range target. The code is bit 7 sign, bits 6:3 exponent (bias 7) and bits 2:0 fraction. Exponent field zero encodes subnormals with weight 2^-9 per fraction step. Finite results are rounded to the nearest value, with ties to even.
- R4: In the narrow-range target, any non-NaN input whose rounded magnitude exceeds 448, including infinity, gives sign|0x7E. No non-NaN input ever gives magnitude code 0x7F.
- R5: fmt_i = 1 selects the wide-range target. The code is bit 7 sign, bits 6:2 exponent (bias 15) and bits 1:0 fraction. Subnormals step by 2^-16. Finite results are rounded to the nearest value, with ties to even.
- R6: In the wide-range target, any input whose rounded magnitude exceeds 57344, including infinity, gives sign|0x7C (infinity).
- R7: A NaN input gives 0x7F in the narrow-range target and 0x7E in the wide-range target, whatever its sign.
- R8: Inputs that round below half the smallest subnormal give a signed zero. This includes zero and single-precision subnormal inputs. An exact half tie rounds to zero.
- R9: For every non-NaN input, bit 7 of the result equals the input sign bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input word is valid |
| data_i | input | 32 | Single-precision input value |
| fmt_i | input | 1 | Target select: 0 narrow-range, 1 wide-range |
| valid_o | output | 1 | Result is valid |
| data_o | output | 8 | 8-bit floating-point result |

## Verification
Several properties are checked on every cycle:
- the one-cycle strobe latency;
- holding of the result register when no word is accepted;
- the absence of the reserved 0x7F magnitude for non-NaN input in the narrow-range target;
- the fixed NaN codes;
- sign propagation;
- zero output for zero-exponent input.

Correct rounding is shown only by the bench scenarios, which compare each result against a nearest-value search over all codes. This covers ties to even, subnormal boundaries, the carry from the fraction into the exponent, and the exact saturation and infinity thresholds.

// File: rtl/fp8_cvt_pkg.sv
package fp8_cvt_pkg;
  typedef enum logic {FMT_NARROW = 1'b0, FMT_WIDE = 1'b1} fmt_e;

  typedef struct packed {
    logic        sign;
    logic        is_nan;
    logic        is_inf;
    logic        is_zero;
    logic [7:0]  exp;
    logic [22:0] man;
  } f32_cls_t;

  localparam int unsigned F32_BIAS = 127;
  localparam int unsigned F32_MAN_W = 23;
endpackage

// File: rtl/fp8_cvt_class.sv
module fp8_cvt_class
  import fp8_cvt_pkg::*;
(
  input  logic [31:0] data_i,
  output f32_cls_t    cls_o
);
  logic all_ones, frac_nz;

  always_comb begin
    all_ones       = &data_i[30:23];
    frac_nz        = |data_i[22:0];
    cls_o.sign     = data_i[31];
    cls_o.exp      = data_i[30:23];
    cls_o.man      = data_i[22:0];
    cls_o.is_nan   = all_ones & frac_nz;
    cls_o.is_inf   = all_ones & ~frac_nz;
    // single-precision subnormals are far below both targets' smallest step
    cls_o.is_zero  = (data_i[30:23] == 8'd0);
  end
endmodule

// File: rtl/fp8_cvt_enc.sv
module fp8_cvt_enc
  import fp8_cvt_pkg::*;
#(
  parameter int unsigned EXP_W       = 4,
  parameter int unsigned MAN_W       = 3,
  parameter int unsigned BIAS        = 7,
  parameter bit          FINITE_ONLY = 1'b1
) (
  input  f32_cls_t                 cls_i,
  output logic [EXP_W+MAN_W:0]     code_o
);
  localparam int unsigned CODE_W   = EXP_W + MAN_W;
  localparam int unsigned DROP     = F32_MAN_W - MAN_W;
  localparam int unsigned SH_MAX   = F32_MAN_W + 2;
  localparam int unsigned EXP_ONES = (1 << EXP_W) - 1;
  localparam int unsigned MAX_CODE = FINITE_ONLY ? ((1 << CODE_W) - 2)
                                                 : ((EXP_ONES << MAN_W) - 1);
  localparam int unsigned OVF_CODE = FINITE_ONLY ? MAX_CODE : (EXP_ONES << MAN_W);
  localparam int unsigned NAN_CODE = FINITE_ONLY ? ((1 << CODE_W) - 1)
                                                 : ((EXP_ONES << MAN_W) | (1 << (MAN_W - 1)));

  int          te;
  int unsigned sh;
  logic [31:0] sig, q, rem_mask, base, code;
  logic        guard, sticky, inc;

  always_comb begin
    te  = int'({24'd0, cls_i.exp}) - int'(F32_BIAS) + int'(BIAS);
    sh  = DROP;
    if (te < 1) sh = DROP + 32'(1 - te);
    if (sh > SH_MAX) sh = SH_MAX;
    sig      = {8'd0, 1'b1, cls_i.man};
    q        = sig >> sh;
    guard    = |((sig >> (sh - 1)) & 32'd1);
    rem_mask = (32'd1 << (sh - 1)) - 32'd1;
    sticky   = |(sig & rem_mask);
    inc      = guard & (sticky | q[0]);
    // hidden bit of q lands in the exponent field; a rounding carry bumps it
    base     = (te >= 1) ? (32'(te - 1) << MAN_W) : 32'd0;
    code     = base + q + {31'd0, inc};

    if (cls_i.is_nan)
      code_o = {1'b0, CODE_W'(NAN_CODE)};
    else if (cls_i.is_zero)
      code_o = {cls_i.sign, {CODE_W{1'b0}}};
    else if (cls_i.is_inf || te > int'(EXP_ONES + 1) || code > MAX_CODE)
      code_o = {cls_i.sign, CODE_W'(OVF_CODE)};
    else
      code_o = {cls_i.sign, code[CODE_W-1:0]};
  end
endmodule

// File: rtl/fp8_cvt.sv
module fp8_cvt
  import fp8_cvt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [31:0] data_i,
  input  logic        fmt_i,
  output logic        valid_o,
  output logic [7:0]  data_o
);
  f32_cls_t   cls;
  logic [7:0] code_nar, code_wid, code_sel;

  fp8_cvt_class u_class (.data_i(data_i), .cls_o(cls));

  fp8_cvt_enc #(.EXP_W(4), .MAN_W(3), .BIAS(7), .FINITE_ONLY(1'b1))
    u_enc_nar (.cls_i(cls), .code_o(code_nar));

  fp8_cvt_enc #(.EXP_W(5), .MAN_W(2), .BIAS(15), .FINITE_ONLY(1'b0))
    u_enc_wid (.cls_i(cls), .code_o(code_wid));

  assign code_sel = (fmt_e'(fmt_i) == FMT_WIDE) ? code_wid : code_nar;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= 8'd0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= code_sel;
    end
  end
endmodule

// File: rtl/fp8_cvt_chk.sv
module fp8_cvt_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [31:0] data_i,
  input logic        fmt_i,
  input logic        valid_o,
  input logic [7:0]  data_o
);
  logic in_nan;
  assign in_nan = (&data_i[30:23]) & (|data_i[22:0]);

  p_valid_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> $stable(data_o));

  p_no_7f_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(fmt_i) && !$past(in_nan)) |-> (data_o[6:0] != 7'h7F));

  p_nan_nar_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(fmt_i) && $past(in_nan)) |-> (data_o == 8'h7F));

  p_nan_wid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(fmt_i) && $past(in_nan)) |-> (data_o == 8'h7E));

  p_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ($past(data_i[30:23]) == 8'd0)) |-> (data_o[6:0] == 7'd0));

  p_sign_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(in_nan)) |-> (data_o[7] == $past(data_i[31])));
endmodule

bind fp8_cvt fp8_cvt_chk u_chk (.*);

// File: tb/fp8_cvt_bench.sv
module fp8_cvt_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] data_i = 32'd0;
  logic        fmt_i = 1'b0;
  logic        valid_o;
  logic [7:0]  data_o;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  fp8_cvt u_fp8_cvt (.*);

  function automatic real pow2(int e);
    real r = 1.0;
    if (e >= 0) for (int i = 0; i < e; i++) r = r * 2.0;
    else        for (int i = 0; i < -e; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic real f32_mag(logic [31:0] b);
    int e = int'(b[30:23]);
    if (e == 0) return 0.0;
    return (1.0 + real'(b[22:0]) / pow2(23)) * pow2(e - 127);
  endfunction

  // magnitude of a 7-bit code in the chosen target
  function automatic real dec_mag(int c, bit wide);
    int mw = wide ? 2 : 3;
    int bias = wide ? 15 : 7;
    int e = c >> mw;
    int m = c & ((1 << mw) - 1);
    if (e == 0) return real'(m) * pow2(1 - bias - mw);
    return (1.0 + real'(m) / pow2(mw)) * pow2(e - bias);
  endfunction

  function automatic logic [7:0] ref_cvt(logic [31:0] b, bit wide);
    real x, best_d, d;
    int best;
    int maxc = wide ? 123 : 126;
    if ((&b[30:23]) && (|b[22:0])) return wide ? 8'h7E : 8'h7F;
    if (&b[30:23]) return {b[31], wide ? 7'h7C : 7'h7E};
    x = f32_mag(b);
    if (wide && x >= 61440.0) return {b[31], 7'h7C};
    if (!wide && x >= 448.0) return {b[31], 7'h7E};
    best = 0;
    best_d = x;
    for (int c = 1; c <= maxc; c++) begin
      d = dec_mag(c, wide) - x;
      if (d < 0.0) d = -d;
      if (d < best_d || (d == best_d && (c % 2 == 0))) begin
        best = c;
        best_d = d;
      end
    end
    return {b[31], 7'(best)};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp_v);
    tests++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp_v);
    end
  endtask

  task automatic conv(logic [31:0] b, bit wide, string req);
    @(negedge clk_i);
    valid_i = 1'b1;
    data_i  = b;
    fmt_i   = wide;
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R1 valid", {7'd0, valid_o}, 8'd1);
    check(req, data_o, ref_cvt(b, wide));
  endtask

  task automatic conv_lit(logic [31:0] b, bit wide, logic [7:0] exp_v, string req);
    @(negedge clk_i);
    valid_i = 1'b1;
    data_i  = b;
    fmt_i   = wide;
    @(negedge clk_i);
    valid_i = 1'b0;
    check(req, data_o, exp_v);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd1357));
    #1;
    check("R1 reset data", data_o, 8'd0);
    check("R1 reset valid", {7'd0, valid_o}, 8'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // directed corners with literal expectations
    conv_lit(32'h3F800000, 1'b0, 8'h38, "R3 one");
    conv_lit(32'h3F800000, 1'b1, 8'h3C, "R5 one");
    conv_lit(32'h43E00000, 1'b0, 8'h7E, "R4 max 448");
    conv_lit(32'h43F00000, 1'b0, 8'h7E, "R4 480 saturates");
    conv_lit(32'hFF800000, 1'b0, 8'hFE, "R4 -inf saturates");
    conv_lit(32'h7F800000, 1'b1, 8'h7C, "R6 inf");
    conv_lit(32'h47600000, 1'b1, 8'h7B, "R5 max 57344");
    conv_lit(32'hC7700000, 1'b1, 8'hFC, "R6 tie 61440 to inf");
    conv_lit(32'h7FC00000, 1'b0, 8'h7F, "R7 nan narrow");
    conv_lit(32'hFFC00001, 1'b1, 8'h7E, "R7 nan wide");
    conv_lit(32'h3B000000, 1'b0, 8'h01, "R3 min subnormal 2^-9");
    conv_lit(32'h37800000, 1'b1, 8'h01, "R5 min subnormal 2^-16");
    conv_lit(32'h3A800000, 1'b0, 8'h00, "R8 half tie to zero");
    conv_lit(32'h3A800001, 1'b0, 8'h01, "R8 above half rounds up");
    conv_lit(32'h80000000, 1'b1, 8'h80, "R8 negative zero");
    conv_lit(32'h00400000, 1'b0, 8'h00, "R8 f32 subnormal");
    conv_lit(32'h3F880000, 1'b0, 8'h38, "R3 tie to even down");
    conv_lit(32'h3F980000, 1'b0, 8'h3A, "R3 tie to even up");
    conv_lit(32'h3FF80000, 1'b0, 8'h40, "R3 carry into exponent");
    conv_lit(32'hBF800000, 1'b0, 8'hB8, "R9 sign");

    // hold with valid low
    held = data_o;
    @(negedge clk_i);
    data_i = 32'h40000000;
    fmt_i  = 1'b1;
    @(negedge clk_i);
    check("R2 hold", data_o, held);
    check("R1 valid low", {7'd0, valid_o}, 8'd0);

    // exponent sweep, both targets
    for (int e = 100; e <= 145; e++) begin
      conv({1'b0, 8'(e), 23'h000000}, 1'b0, "R3 sweep");
      conv({1'b1, 8'(e), 23'h100000}, 1'b1, "R5 sweep");
    end

    // random with tie-biased fractions
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] b;
      bit w;
      b = $urandom;
      b[30:23] = 8'(100 + ($urandom % 46));
      if ($urandom % 3 == 0) b[18:0] = 19'h40000;
      if ($urandom % 5 == 0) b[19:0] = 20'h80000;
      w = 1'($urandom);
      conv(b, w, w ? "R6 R5 random" : "R4 R3 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule